// File: doc/BRIEF.md
# State Equivalence Finder

This block takes the transition and output table of a small clocked state machine and works out which pairs of states are equivalent. Two states count as equivalent when every input combination gives them the same output and sends them to states that are themselves equivalent. The block finds these pairs by elimination. It first marks every pair whose outputs disagree. It then keeps marking any pair that leads to a marked pair, and stops when a whole pass adds no mark.

The table is written one entry at a time through a write port, indexed by state and input combination. A separate configuration write sets how many states and how many input combinations are in use. A start pulse launches the search. When the search ends, `done_o` rises and the results appear on two outputs: a triangular vector with one bit per unordered pair of states, and one class representative index per state.

Top module: `st_equiv_engine`

## Requirements
- R1: After the asynchronous reset, `done_o` and `busy_o` are 0, `equiv_o` is all zero and every representative equals its own state index.
- R2: While the block is not busy, a write with `wr_en_i` stores `wr_next_i` and `wr_out_i` for the entry (`wr_state_i`, `wr_combo_i`). A write with `cfg_we_i` sets the active state count (1 to 8) and the active combination count (1 to 4). Both counts reset to their maxima.
- R3: On a `start_i` pulse while idle or done, `done_o` drops and `busy_o` rises on the next edge. When the search ends, `busy_o` drops and `done_o` rises. `done_o` then holds until the next start.
- R4: Two active states whose outputs differ under any active combination are reported as not equivalent.
- R5: A pair becomes not equivalent when, under any active combination, it leads to a pair already found not equivalent. This is repeated until nothing changes, so chains of any length are followed.
- R6: An implied pair made of one state twice never makes the pair that implies it not equivalent.
- R7: Table entries for combinations at or above the active combination count have no effect on the result.
- R8: A state at or above the active state count is reported equivalent to no other state and is its own representative.
- R9: Bit j*(j-1)/2+i of `equiv_o` (i<j) is 1 exactly when states i and j are equivalent. This holds while `done_o` is high; the vector is all zero otherwise.
- R10: Field s of `rep_o` (bits 3s+2..3s) holds the lowest state index equivalent to s, or s itself if no lower state is equivalent.
- R11: While busy, `start_i`, table writes and configuration writes are ignored.
- R12: With the default 8 states, `done_o` is high 56 edges after the edge that samples `start_i` when the first propagation pass adds no mark. Each further pass adds 28 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table entry write strobe |
| wr_state_i | input | 3 | State index of the entry written |
| wr_combo_i | input | 2 | Input combination index of the entry written |
| wr_next_i | input | 3 | Next-state index stored |
| wr_out_i | input | 1 | Output value stored |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_states_i | input | 4 | Active state count |
| cfg_combos_i | input | 3 | Active combination count |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Results valid |
| equiv_o | output | 28 | Pair equivalence bits |
| rep_o | output | 24 | Class representative per state, 3 bits each |

## Verification
The bench goes after several corner cases:
- A five-state machine in which a mark reaches its last pair only on a later pass. A design that stops after one propagation pass would wrongly report that pair as equivalent.
- Machines whose next states all coincide. A design that lets an implied self-pair mark its parent would report no equivalence at all.
- Inactive combinations and inactive states carrying conflicting entries. A design that ignores the counts would change the result.
- A start pulse, table write and configuration write issued during a run. A design that restarts or accepts the write would finish late or give a different answer.
- Exact start-to-done latency. An extra or missing pass would show up as a shift in the cycle where `done_o` rises.

// File: rtl/st_eq_pkg.sv
package st_eq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_PASS,
    ST_DONE
  } eng_st_e;
endpackage

// File: rtl/st_eq_table.sv
module st_eq_table #(
  parameter int N_ST  = 8,
  parameter int N_CMB = 4,
  localparam int IW  = $clog2(N_ST),
  localparam int CW  = $clog2(N_CMB),
  localparam int SCW = $clog2(N_ST + 1),
  localparam int CCW = $clog2(N_CMB + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           lock_i,
  input  logic           we_i,
  input  logic [IW-1:0]  st_i,
  input  logic [CW-1:0]  cmb_i,
  input  logic [IW-1:0]  nxt_i,
  input  logic           out_i,
  input  logic           cfg_we_i,
  input  logic [SCW-1:0] cfg_st_i,
  input  logic [CCW-1:0] cfg_cmb_i,
  output logic [IW-1:0]  nxt_tab_o [N_ST][N_CMB],
  output logic           out_tab_o [N_ST][N_CMB],
  output logic [SCW-1:0] n_st_o,
  output logic [CCW-1:0] n_cmb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_tab_o <= '{default: '0};
      out_tab_o <= '{default: 1'b0};
    end else if (we_i && !lock_i) begin
      nxt_tab_o[st_i][cmb_i] <= nxt_i;
      out_tab_o[st_i][cmb_i] <= out_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_st_o  <= SCW'(N_ST);
      n_cmb_o <= CCW'(N_CMB);
    end else if (cfg_we_i && !lock_i) begin
      n_st_o  <= cfg_st_i;
      n_cmb_o <= cfg_cmb_i;
    end
  end

  p_cfg_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(n_st_o) && $stable(n_cmb_o)));
endmodule

// File: rtl/st_eq_engine.sv
module st_eq_engine
  import st_eq_pkg::*;
#(
  parameter int N_ST  = 8,
  parameter int N_CMB = 4,
  localparam int IW  = $clog2(N_ST),
  localparam int SCW = $clog2(N_ST + 1),
  localparam int CCW = $clog2(N_CMB + 1),
  localparam int NP  = N_ST * (N_ST - 1) / 2,
  localparam int PW  = $clog2(NP)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [IW-1:0]  nxt_tab_i [N_ST][N_CMB],
  input  logic           out_tab_i [N_ST][N_CMB],
  input  logic [SCW-1:0] n_st_i,
  input  logic [CCW-1:0] n_cmb_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [NP-1:0]  mark_o
);
  eng_st_e        st_q;
  logic [IW-1:0]  i_q, j_q;
  logic [PW-1:0]  idx_q;
  logic           chg_q;
  logic [NP-1:0]  mark_q;
  logic [N_CMB-1:0] diff_v, hit_v;
  logic           diff, hit, last, inactive, set_now;

  function automatic logic [PW-1:0] pidx(logic [IW-1:0] lo, logic [IW-1:0] hi);
    int t;
    t = int'(hi) * (int'(hi) - 1) / 2 + int'(lo);
    return PW'(t);
  endfunction

  for (genvar c = 0; c < N_CMB; c++) begin : g_cmb
    logic          en;
    logic [IW-1:0] a, b, lo, hi;
    assign en = (CCW'(c) < n_cmb_i);
    assign a  = nxt_tab_i[i_q][c];
    assign b  = nxt_tab_i[j_q][c];
    assign lo = (a < b) ? a : b;
    assign hi = (a < b) ? b : a;
    assign diff_v[c] = en && (out_tab_i[i_q][c] != out_tab_i[j_q][c]);
    // same-state implied pair never marks
    assign hit_v[c]  = en && (a != b) && (int'(hi) < N_ST) && mark_q[pidx(lo, hi)];
  end

  assign diff     = |diff_v;
  assign hit      = |hit_v;
  assign last     = (idx_q == PW'(NP - 1));
  assign inactive = (int'(j_q) >= int'(n_st_i));
  assign set_now  = (st_q == ST_PASS) && !mark_q[idx_q] && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      i_q    <= '0;
      j_q    <= IW'(1);
      idx_q  <= '0;
      chg_q  <= 1'b0;
      mark_q <= '0;
      done_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            st_q   <= ST_INIT;
            i_q    <= '0;
            j_q    <= IW'(1);
            idx_q  <= '0;
            chg_q  <= 1'b0;
            mark_q <= '0;
            done_o <= 1'b0;
          end
        end
        ST_INIT, ST_PASS: begin
          if (st_q == ST_INIT) begin
            mark_q[idx_q] <= diff || inactive;
          end else if (set_now) begin
            mark_q[idx_q] <= 1'b1;
          end
          if (last) begin
            i_q   <= '0;
            j_q   <= IW'(1);
            idx_q <= '0;
            chg_q <= 1'b0;
            if (st_q == ST_INIT) begin
              st_q <= ST_PASS;
            end else if (!(chg_q || set_now)) begin
              st_q   <= ST_DONE;
              done_o <= 1'b1;
            end
          end else begin
            idx_q <= idx_q + PW'(1);
            if (st_q == ST_PASS && set_now) chg_q <= 1'b1;
            if (i_q == j_q - IW'(1)) begin
              i_q <= '0;
              j_q <= j_q + IW'(1);
            end else begin
              i_q <= i_q + IW'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == ST_INIT) || (st_q == ST_PASS);
  assign mark_o = mark_q;

  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  p_mark_mono_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PASS) |=> ((mark_q & $past(mark_q)) == $past(mark_q)));
  p_scan_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> (busy_o && idx_q == $past(idx_q) + PW'(1)));
endmodule

// File: rtl/st_eq_class.sv
module st_eq_class #(
  parameter int N_ST = 8,
  localparam int IW = $clog2(N_ST),
  localparam int NP = N_ST * (N_ST - 1) / 2
) (
  input  logic [NP-1:0]      eq_i,
  output logic [N_ST*IW-1:0] rep_o
);
  for (genvar s = 0; s < N_ST; s++) begin : g_st
    logic [IW-1:0] ch [0:s];
    assign ch[s] = IW'(s);
    // lowest equivalent index wins
    for (genvar t = 0; t < s; t++) begin : g_lo
      assign ch[t] = eq_i[s * (s - 1) / 2 + t] ? IW'(t) : ch[t + 1];
    end
    assign rep_o[s*IW +: IW] = ch[0];
  end
endmodule

// File: rtl/st_equiv_engine.sv
module st_equiv_engine #(
  parameter int N_ST  = 8,
  parameter int N_CMB = 4,
  localparam int IW  = $clog2(N_ST),
  localparam int CW  = $clog2(N_CMB),
  localparam int SCW = $clog2(N_ST + 1),
  localparam int CCW = $clog2(N_CMB + 1),
  localparam int NP  = N_ST * (N_ST - 1) / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IW-1:0]       wr_state_i,
  input  logic [CW-1:0]       wr_combo_i,
  input  logic [IW-1:0]       wr_next_i,
  input  logic                wr_out_i,
  input  logic                cfg_we_i,
  input  logic [SCW-1:0]      cfg_states_i,
  input  logic [CCW-1:0]      cfg_combos_i,
  input  logic                start_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [NP-1:0]       equiv_o,
  output logic [N_ST*IW-1:0]  rep_o
);
  logic [IW-1:0]  nxt_tab [N_ST][N_CMB];
  logic           out_tab [N_ST][N_CMB];
  logic [SCW-1:0] n_st;
  logic [CCW-1:0] n_cmb;
  logic [NP-1:0]  mark;

  st_eq_table #(.N_ST(N_ST), .N_CMB(N_CMB)) i_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (busy_o),
    .we_i      (wr_en_i),
    .st_i      (wr_state_i),
    .cmb_i     (wr_combo_i),
    .nxt_i     (wr_next_i),
    .out_i     (wr_out_i),
    .cfg_we_i  (cfg_we_i),
    .cfg_st_i  (cfg_states_i),
    .cfg_cmb_i (cfg_combos_i),
    .nxt_tab_o (nxt_tab),
    .out_tab_o (out_tab),
    .n_st_o    (n_st),
    .n_cmb_o   (n_cmb)
  );

  st_eq_engine #(.N_ST(N_ST), .N_CMB(N_CMB)) i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .nxt_tab_i (nxt_tab),
    .out_tab_i (out_tab),
    .n_st_i    (n_st),
    .n_cmb_i   (n_cmb),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .mark_o    (mark)
  );

  assign equiv_o = done_o ? ~mark : '0;

  st_eq_class #(.N_ST(N_ST)) i_class (
    .eq_i  (equiv_o),
    .rep_o (rep_o)
  );

  logic [IW-1:0] rep_a [N_ST];
  for (genvar s = 0; s < N_ST; s++) begin : g_rep_chk
    assign rep_a[s] = rep_o[s*IW +: IW];
    p_rep_root_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (rep_a[rep_a[s]] == rep_a[s] && rep_a[s] <= IW'(s)));
  end
endmodule

// File: tb/test_st_equiv_engine.sv
module test_st_equiv_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_state = '0;
  logic [1:0]  wr_combo = '0;
  logic [2:0]  wr_next = '0;
  logic        wr_out = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_states = 4'd8;
  logic [2:0]  cfg_combos = 3'd4;
  logic        start = 1'b0;
  logic        busy, done;
  logic [27:0] equiv;
  logic [23:0] rep;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [23:0] REP_ID = 24'hFAC688;

  always #5 clk = ~clk;

  st_equiv_engine i_st_equiv_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_state_i(wr_state), .wr_combo_i(wr_combo),
    .wr_next_i(wr_next), .wr_out_i(wr_out),
    .cfg_we_i(cfg_we), .cfg_states_i(cfg_states), .cfg_combos_i(cfg_combos),
    .start_i(start), .busy_o(busy), .done_o(done),
    .equiv_o(equiv), .rep_o(rep)
  );

  typedef struct packed {
    logic [3:0]  kind;
    logic [3:0]  ns;
    logic [2:0]  nc;
    logic [27:0] eq;
    logic [23:0] rp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd0, 4'd5, 3'd2, 28'h0,       REP_ID},
    '{4'd1, 4'd8, 3'd4, 28'hFFFFFFF, 24'h0},
    '{4'd2, 4'd4, 3'd2, 28'h12,      {3'd7,3'd6,3'd5,3'd4,3'd1,3'd0,3'd1,3'd0}},
    '{4'd3, 4'd4, 3'd2, 28'h0,       REP_ID},
    '{4'd3, 4'd4, 3'd1, 28'h12,      {3'd7,3'd6,3'd5,3'd4,3'd1,3'd0,3'd1,3'd0}},
    '{4'd1, 4'd3, 3'd4, 28'h7,       {3'd7,3'd6,3'd5,3'd4,3'd3,3'd0,3'd0,3'd0}},
    '{4'd4, 4'd8, 3'd1, 28'h54AA952, {3'd1,3'd0,3'd1,3'd0,3'd1,3'd0,3'd1,3'd0}}
  };

  function automatic string req_of(int v);
    case (v)
      0: return "R5";
      1: return "R6";
      3: return "R4";
      4: return "R7";
      5: return "R8";
      default: return "R10";
    endcase
  endfunction

  // entry (s,c) at bits [(s*4+c)*4 +: 4] = {next, out}
  function automatic logic [127:0] build_tbl(int k);
    logic [127:0] t = '0;
    logic [2:0] nx;
    logic o;
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 4; c++) begin
        nx = 3'd0; o = 1'b0;
        case (k)
          0: begin
            case ({s[2:0], c[1:0]})
              5'b000_00: begin nx = 3'd1; o = 1'b1; end
              5'b000_01: begin nx = 3'd0; o = 1'b1; end
              5'b001_00: begin nx = 3'd0; o = 1'b0; end
              5'b001_01: begin nx = 3'd2; o = 1'b1; end
              5'b010_00: begin nx = 3'd3; o = 1'b1; end
              5'b010_01: begin nx = 3'd0; o = 1'b1; end
              5'b011_00: begin nx = 3'd3; o = 1'b0; end
              5'b011_01: begin nx = 3'd4; o = 1'b1; end
              5'b100_00: begin nx = 3'd2; o = 1'b0; end
              5'b100_01: begin nx = 3'd3; o = 1'b0; end
              default: ;
            endcase
          end
          2, 3: begin
            if (s < 4 && c < 2) begin
              nx = (c == 0) ? 3'(s) : 3'((s + 1) % 4);
              o  = s[0];
              if (k == 3 && s == 3 && c == 1) o = 1'b0;
            end
          end
          4: begin
            nx = (c == 0) ? 3'(s) : 3'((s + 1) % 8);
            o  = s[0];
          end
          default: ;
        endcase
        t[(s*4+c)*4 +: 4] = {nx, o};
      end
    end
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [127:0] t, input logic [3:0] ns, input logic [2:0] nc);
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_state = 3'(s); wr_combo = 2'(c);
        {wr_next, wr_out} = t[(s*4+c)*4 +: 4];
      end
    end
    @(negedge clk);
    wr_en = 1'b0; cfg_we = 1'b1; cfg_states = ns; cfg_combos = nc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 4000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    check(done == 1'b0 && busy == 1'b0, "R1", "flags in reset", {30'd0, done, busy}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(equiv == '0, "R1", "equiv after reset", 32'(equiv), 32'd0);
    check(rep == REP_ID, "R1", "rep after reset", 32'(rep), 32'(REP_ID));

    // R2 vector walk
    for (int v = 0; v < 7; v++) begin
      load(build_tbl(int'(VECS[v].kind)), VECS[v].ns, VECS[v].nc);
      kick();
      wait_done();
      check(done == 1'b1, "R3", "done reached", 32'(done), 32'd1);
      check(equiv == VECS[v].eq, req_of(v), $sformatf("R2 R9 equiv vec %0d", v),
            32'(equiv), 32'(VECS[v].eq));
      check(rep == VECS[v].rp, req_of(v), $sformatf("R10 rep vec %0d", v),
            32'(rep), 32'(VECS[v].rp));
    end

    // R3 done holds, R12 latency, R9 quiet while busy
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R3", "done held while idle", 32'(done), 32'd1);
    load(build_tbl(1), 4'd8, 3'd4);
    kick();
    check(done == 1'b0 && busy == 1'b1, "R3", "busy after start", {30'd0, done, busy}, 32'd1);
    check(equiv == '0, "R9", "equiv zero while busy", 32'(equiv), 32'd0);
    repeat (55) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R12", "done before edge 56", 32'(done), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R12", "done at edge 56", {30'd0, done, busy}, 32'd2);

    // R11 start, write and config while busy ignored
    load(build_tbl(2), 4'd4, 3'd2);
    kick();
    repeat (9) @(posedge clk);
    @(negedge clk);
    start = 1'b1; wr_en = 1'b1; wr_state = 3'd0; wr_combo = 2'd0;
    wr_next = 3'd5; wr_out = 1'b1;
    cfg_we = 1'b1; cfg_states = 4'd2; cfg_combos = 3'd1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0; cfg_we = 1'b0;
    repeat (45) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R11", "no early done", 32'(done), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b1, "R11", "start mid-run did not restart", 32'(done), 32'd1);
    check(equiv == 28'h12, "R11", "equiv after mid-run pulses", 32'(equiv), 32'h12);
    kick();
    wait_done();
    check(equiv == 28'h12, "R11", "busy write and cfg dropped", 32'(equiv), 32'h12);

    // R1 reset mid-state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && equiv == '0 && rep == REP_ID, "R1", "second reset",
          {3'd0, done, equiv}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule